// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a slave on an open-drain two-wire serial bus. It brings the clock and data lines into the system clock domain, recognises start and stop conditions, and assembles bytes most significant bit first. It answers the address byte when the address matches, and acknowledges every command and data byte that follows. Received bytes reach a command layer through a one-cycle strobe with a position index. Read data comes back through a load port and is shifted out on the bus. The data output is an open-drain pull enable: when it is asserted, the line is driven low.

The address byte carries a fixed four-bit device type in its upper half and four strap inputs in its lower half. A busy input suppresses the address acknowledge while a nonvolatile write is still running. A master can therefore poll for completion by repeating start plus address until the acknowledge returns. A stop that ends an addressed transaction is reported to the command layer as a one-cycle pulse, because the nonvolatile write cycle starts at that stop.

Top module: `twi_slave_front`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop that ends an addressed transaction raises `xfer_end_o` for exactly one cycle. A stop after an unmatched address does not raise it.
- R2: Before the first start condition, clocked bus activity produces no acknowledge and no byte strobe.
- R3: The slave acknowledges the address byte only when bits 7..4 equal binary 0101 and bits 3..0 equal `strap_i`. For any other address it stays silent until the next start.
- R4: If `busy_i` is high at the end of the address byte, the address is not acknowledged. Once `busy_i` is low, the same address is acknowledged again.
- R5: Each byte after the address is acknowledged by pulling the data line low during the ninth clock. `rx_valid_o` pulses for one cycle with the byte on `rx_data_o` and its index on `rx_idx_o`. The index is 0 for the command byte, and each later byte adds 1, saturating at 3.
- R6: Bits are received most significant bit first, each sampled on a rising edge of the clock line.
- R7: If `tx_load_i` is pulsed during the acknowledge of a byte, the next byte is driven by the slave, most significant bit first, with a 0 bit pulling the line low. The slave releases the line for the ninth clock. After the master signals no-acknowledge (line high), the slave stays silent until stop or start.
- R8: The pull enable changes only while the clock line is low, except that start and stop release it.
- R9: A start seen in the middle of a byte aborts the transfer and restarts address reception.
- R10: After reset the pull enable is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved) |
| strap_i | input | 4 | Low address nibble straps |
| busy_i | input | 1 | Nonvolatile write in progress; withholds the address acknowledge |
| tx_load_i | input | 1 | Load a read byte for the next byte slot |
| tx_data_i | input | 8 | Read byte to load |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_idx_o | output | 2 | Byte position after the address, saturating |
| xfer_end_o | output | 1 | One-cycle pulse at the stop of an addressed transaction |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, 8-bit bytes, four strap bits and a 2-bit byte index. The narrow index makes saturation reachable with only five bytes after the address. Two synchronizer stages give a fixed three-cycle reaction to a line edge, so a bus half period of eight system clocks lets the reference model predict the pull enable exactly on every clock. The strap value is changed between transactions, so address matching is exercised against more than one strap value.

// File: rtl/twi_slave_pkg.sv
`timescale 1ns/1ps
package twi_slave_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } eng_st_e;
endpackage

// File: rtl/twi_sync_edge.sv
`timescale 1ns/1ps
module twi_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/twi_bus_cond.sv
`timescale 1ns/1ps
module twi_bus_cond (
    input  logic scl_lvl_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o
);
    // data edges while the clock line rests high are framing events
    assign start_o = scl_lvl_i & sda_fall_i;
    assign stop_o  = scl_lvl_i & sda_rise_i;
endmodule

// File: rtl/twi_byte_engine.sv
`timescale 1ns/1ps
module twi_byte_engine
    import twi_slave_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int STRAP_W = 4,
    parameter int IDX_W   = 2,
    parameter logic [BYTE_W-STRAP_W-1:0] DEV_ID = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_lvl_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               tx_load_i,
    input  logic [BYTE_W-1:0]  tx_data_i,
    output logic               sda_pull_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_data_o,
    output logic [IDX_W-1:0]   rx_idx_o,
    output logic               xfer_end_o
);
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int IDX_MAX = (1 << IDX_W) - 1;

    typedef struct packed {
        eng_st_e           st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              sel;
        logic [IDX_W-1:0]  nbytes;
        logic              tx_pend;
        logic [BYTE_W-1:0] tx_buf;
        logic              m_ack;
        logic              pull;
        logic              rx_valid;
        logic [BYTE_W-1:0] rx_data;
        logic [IDX_W-1:0]  rx_idx;
        logic              xend;
    } eng_t;

    eng_t              d, q;
    logic              pend_now;
    logic [BYTE_W-1:0] buf_now;
    logic              after_nine;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        d.xend     = 1'b0;
        after_nine = 1'b0;
        pend_now   = q.tx_pend | (tx_load_i & q.sel);
        buf_now    = (tx_load_i & q.sel) ? tx_data_i : q.tx_buf;
        d.tx_pend  = pend_now;
        d.tx_buf   = buf_now;

        if (start_i) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.pull    = 1'b0;
            d.sel     = 1'b0;
            d.nbytes  = '0;
            d.tx_pend = 1'b0;
        end else if (stop_i) begin
            d.st      = ST_IDLE;
            d.pull    = 1'b0;
            d.xend    = q.sel;
            d.sel     = 1'b0;
            d.tx_pend = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_lvl_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == CNT_W'(BYTE_W)) begin
                        d.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh == {DEV_ID, strap_i} && !busy_i) begin
                                d.pull = 1'b1;
                                d.sel  = 1'b1;
                                d.st   = ST_ACK;
                            end else begin
                                d.st   = ST_SKIP;
                            end
                        end else begin
                            d.pull     = 1'b1;
                            d.st       = ST_ACK;
                            d.rx_valid = 1'b1;
                            d.rx_data  = q.sh;
                            d.rx_idx   = q.nbytes;
                            d.nbytes   = (q.nbytes == IDX_W'(IDX_MAX)) ?
                                         q.nbytes : q.nbytes + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) after_nine = 1'b1;
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == CNT_W'(BYTE_W)) begin
                            d.pull = 1'b0;
                            d.st   = ST_TXACK;
                        end else begin
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise_i) begin
                        d.m_ack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        if (q.m_ack) after_nine = 1'b1;
                        else         d.st = ST_SKIP;
                    end
                end
                default: ;
            endcase

            if (after_nine) begin
                d.cnt = '0;
                if (pend_now) begin
                    d.st      = ST_TX;
                    d.sh      = buf_now;
                    d.tx_pend = 1'b0;
                    d.pull    = ~buf_now[BYTE_W-1];
                end else begin
                    d.st      = ST_RX;
                    d.pull    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign rx_valid_o = q.rx_valid;
    assign rx_data_o  = q.rx_data;
    assign rx_idx_o   = q.rx_idx;
    assign xfer_end_o = q.xend;
endmodule

// File: rtl/twi_slave_front.sv
`timescale 1ns/1ps
module twi_slave_front #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int STRAP_W     = 4,
    parameter int IDX_W       = 2,
    parameter logic [BYTE_W-STRAP_W-1:0] DEV_ID = 4'b0101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               tx_load_i,
    input  logic [BYTE_W-1:0]  tx_data_i,
    output logic               sda_pull_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_data_o,
    output logic [IDX_W-1:0]   rx_idx_o,
    output logic               xfer_end_o
);
    localparam int N_LINES = 2;
    localparam int L_SCL   = 0;
    localparam int L_SDA   = 1;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    logic               scl_lvl;
    logic               start_p, stop_p;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twi_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (raw[g]),
            .lvl_o  (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    assign scl_lvl = lvl[L_SCL];

    twi_bus_cond u_cond (
        .scl_lvl_i  (scl_lvl),
        .sda_rise_i (rise[L_SDA]),
        .sda_fall_i (fall[L_SDA]),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    twi_byte_engine #(
        .BYTE_W (BYTE_W),
        .STRAP_W(STRAP_W),
        .IDX_W  (IDX_W),
        .DEV_ID (DEV_ID)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (rise[L_SCL]),
        .scl_fall_i (fall[L_SCL]),
        .sda_lvl_i  (lvl[L_SDA]),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .strap_i    (strap_i),
        .busy_i     (busy_i),
        .tx_load_i  (tx_load_i),
        .tx_data_i  (tx_data_i),
        .sda_pull_o (sda_pull_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rx_idx_o   (rx_idx_o),
        .xfer_end_o (xfer_end_o)
    );
endmodule

// File: rtl/twi_slave_front_chk.sv
`timescale 1ns/1ps
module twi_slave_front_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic start_p,
    input logic stop_p,
    input logic sda_pull_o,
    input logic rx_valid_o,
    input logic xfer_end_o
);
    // R8: pull moves only in the low clock phase unless framing released it
    p_pull_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_lvl));

    // R5: a delivered byte is acknowledged in the same cycle
    p_ack_with_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> sda_pull_o);

    // R5: byte strobe lasts one cycle
    p_byte_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R9: a start always releases the line
    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_pull_o);

    // R1: end pulse only follows a stop
    p_end_after_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end_o |-> $past(stop_p));
endmodule

bind twi_slave_front twi_slave_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .start_p    (start_p),
    .stop_p     (stop_p),
    .sda_pull_o (sda_pull_o),
    .rx_valid_o (rx_valid_o),
    .xfer_end_o (xfer_end_o)
);

// File: tb/twi_slave_front_test.sv
`timescale 1ns/1ps
module twi_slave_front_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'hA;
    logic       busy = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sda_pull, rx_valid, xfer_end;
    logic [7:0] rx_data;
    logic [1:0] rx_idx;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int settle_until = 1000000;
    int xend_cnt = 0;
    bit exp_pull = 1'b0;
    bit done = 1'b0;
    string cur_req = "R8";
    logic [9:0] rxq[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    twi_slave_front uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .busy_i(busy), .tx_load_i(tx_load), .tx_data_i(tx_data),
        .sda_pull_o(sda_pull), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rx_idx_o(rx_idx), .xfer_end_o(xfer_end)
    );

    task automatic chk(input string req, input int got, input int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, expv);
        end
    endtask

    // reference model: expected pull enable tracked every clock
    always @(negedge clk) begin
        cyc++;
        if (rx_valid) rxq.push_back({rx_idx, rx_data});
        if (xfer_end) xend_cnt++;
        if (rst_n && cyc >= settle_until) chk(cur_req, int'(sda_pull), int'(exp_pull));
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_exp(input bit v);
        settle_until = cyc + 5;
        exp_pull = v;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; step(HALF/2);
        scl = 1'b1;   step(HALF/2);
        sda_m = 1'b0; set_exp(1'b0); step(HALF/2);
        scl = 1'b0;   step(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; step(HALF/2);
        scl = 1'b1;   step(HALF/2);
        sda_m = 1'b1; set_exp(1'b0); step(HALF);
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; step(HALF);
        scl = 1'b1; step(HALF);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] dv, input bit ack, input bit do_load,
                             input logic [7:0] ld, input string req);
        for (int i = 7; i >= 0; i--) put_bit(dv[i]);
        set_exp(ack);
        sda_m = 1'b1;
        step(6);
        if (do_load) begin
            tx_data = ld; tx_load = 1'b1; step(1); tx_load = 1'b0; step(HALF-7);
        end else step(HALF-6);
        scl = 1'b1; step(HALF/2);
        chk(req, int'(sda_line), int'(!ack));
        step(HALF/2);
        scl = 1'b0;
        set_exp(do_load && ack ? ~ld[7] : 1'b0);
    endtask

    task automatic read_byte(input logic [7:0] ev, input bit m_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; step(HALF);
            scl = 1'b1; step(HALF/2);
            chk(req, int'(sda_line), int'(ev[i]));
            step(HALF/2);
            scl = 1'b0;
            set_exp(i > 0 ? ~ev[i-1] : 1'b0);
        end
        put_bit(!m_ack);
    endtask

    task automatic expect_rx(input int idx, input int dv, input string req);
        logic [9:0] e;
        if (rxq.size() == 0) begin
            checks++; fails++;
            $display("FAIL %s: got no byte expected %0h", req, dv);
        end else begin
            e = rxq.pop_front();
            chk(req, int'(e[7:0]), dv);
            chk(req, int'(e[9:8]), idx);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int xb;
        step(4);
        // R10: reset state
        chk("R10", int'(sda_pull), 0);
        chk("R10", int'(rx_valid), 0);
        chk("R10", int'(xfer_end), 0);
        rst_n = 1'b1;
        settle_until = cyc + 2;
        step(4);

        // R2: matching byte clocked with no start is ignored
        scl = 1'b0; step(HALF);
        cur_req = "R2";
        send_byte(8'h5A, 1'b0, 1'b0, 8'h00, "R2");
        step(HALF);
        chk("R2", rxq.size(), 0);

        // R3 R5 R6: full write with index saturation
        cur_req = "R5";
        xb = xend_cnt;
        bus_start();
        send_byte(8'h5A, 1'b1, 1'b0, 8'h00, "R3");
        send_byte(8'h3C, 1'b1, 1'b0, 8'h00, "R5");
        send_byte(8'h81, 1'b1, 1'b0, 8'h00, "R6");
        send_byte(8'h12, 1'b1, 1'b0, 8'h00, "R5");
        send_byte(8'hE7, 1'b1, 1'b0, 8'h00, "R5");
        send_byte(8'h40, 1'b1, 1'b0, 8'h00, "R5");
        bus_stop();
        expect_rx(0, 8'h3C, "R5");
        expect_rx(1, 8'h81, "R6");
        expect_rx(2, 8'h12, "R5");
        expect_rx(3, 8'hE7, "R5");
        expect_rx(3, 8'h40, "R5");
        chk("R1", xend_cnt - xb, 1);

        // R3: strap mismatch and type mismatch are not answered
        cur_req = "R3";
        xb = xend_cnt;
        bus_start();
        send_byte(8'h5B, 1'b0, 1'b0, 8'h00, "R3");
        send_byte(8'h12, 1'b0, 1'b0, 8'h00, "R3");
        bus_stop();
        bus_start();
        send_byte(8'h6A, 1'b0, 1'b0, 8'h00, "R3");
        bus_stop();
        chk("R3", rxq.size(), 0);
        chk("R1", xend_cnt - xb, 0);

        // R4: busy withholds address acknowledge (polling)
        cur_req = "R4";
        busy = 1'b1;
        bus_start();
        send_byte(8'h5A, 1'b0, 1'b0, 8'h00, "R4");
        bus_stop();
        busy = 1'b0;
        xb = xend_cnt;
        bus_start();
        send_byte(8'h5A, 1'b1, 1'b0, 8'h00, "R4");
        bus_stop();
        chk("R1", xend_cnt - xb, 1);

        // R9: start in mid byte restarts address reception
        cur_req = "R9";
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(8'h5A, 1'b1, 1'b0, 8'h00, "R9");
        send_byte(8'h77, 1'b1, 1'b0, 8'h00, "R9");
        bus_stop();
        expect_rx(0, 8'h77, "R9");

        // R7: read with a different strap
        cur_req = "R7";
        strap = 4'h3;
        step(4);
        xb = xend_cnt;
        bus_start();
        send_byte(8'h53, 1'b1, 1'b0, 8'h00, "R7");
        send_byte(8'h90, 1'b1, 1'b1, 8'hA5, "R7");
        read_byte(8'hA5, 1'b0, "R7");
        bus_stop();
        expect_rx(0, 8'h90, "R7");
        chk("R7", rxq.size(), 0);
        chk("R1", xend_cnt - xb, 1);

        // R3: old strap no longer matches
        cur_req = "R3";
        bus_start();
        send_byte(8'h5A, 1'b0, 1'b0, 8'h00, "R3");
        bus_stop();

        step(10);
        done = 1'b1;
        finish_run();
    end
endmodule